// File: doc/BRIEF.md
# Victim Destination Selector for Peer Cache Slices

When one private cache slice on a chip evicts a line, this block decides where the line goes. The line may go to another slice among a group of peers, or it may leave the chip. Every slice keeps a fill-pressure score. The score counts how often the slice's own requester has pulled lines in to service misses, and it fades over time because it is halved once per programmable window. A slice that has no requester reports a score of zero at all times.

An eviction request carries four things: the evicting slice index, the line address, a dirty flag and a vector of the slices that already hold a copy. The block answers with one of three outcomes:

- If a peer already has a copy, ownership moves to that peer.
- Otherwise, if some peer is under less pressure than the evicting slice, the line is placed in the least-pressured peer.
- Otherwise the line is dropped, and a write-back is requested when the line is dirty.

The block accepts one request per cycle. Its answer is registered and appears on the cycle after acceptance.

Top module: `vds_victim_select`

## Requirements
- R1: While `rst_n` is low, `ev_ready_o` and `dec_valid_o` are 0, and every score is 0.
- R2: `ev_ready_o` is 1 from the first clock edge after reset release. A request is accepted when `ev_valid_i` and `ev_ready_o` are both 1 at a rising edge. After that edge, `dec_valid_o` is 1 for exactly one cycle and `dec_addr_o` carries the accepted address. In all other cycles `dec_valid_o` is 0. Back-to-back requests get back-to-back answers.
- R3: Suppose any bit of `ev_present_i` other than the evicting slice's own bit is set. The outcome is then transfer (`dec_kind_o` = 0) to the lowest-indexed such slice, whatever the scores are.
- R4: The evicting slice's own bit in `ev_present_i` is ignored, and the evicting slice is never the destination of a transfer or a placement.
- R5: With no copy elsewhere, the outcome is place (`dec_kind_o` = 1) into the peer with the smallest score among the peers whose score is strictly below the evicting slice's score. Equal scores go to the lower index.
- R6: With no copy elsewhere and no eligible peer, the outcome is drop (`dec_kind_o` = 2) with `dec_dest_o` = 0, and `dec_wb_o` equals the request's dirty flag. For transfer and place, `dec_wb_o` is 0.
- R7: A slice's score rises by 1 at each rising edge where its `fill_i` bit is 1. It saturates at 2^METRIC_W-1 instead of wrapping.
- R8: A slice whose bit is set in parameter FREE_MASK (by default slice 9) always scores 0. Its `fill_i` bit has no effect.
- R9: With a nonzero `window_len_i` = W held steady from a point where the window counter is idle, every score is halved (shifted right by one) at the W-th edge. A fill on that same edge is lost. While `window_len_i` is 0, no halving ever happens.
- R10: `dec_kind_o` never shows the unused code 3 while `dec_valid_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fill_i | input | NUM_SLICES | Per-slice demand-fill pulse from the local requester |
| window_len_i | input | WIN_W | Decay window length in cycles, 0 disables decay |
| ev_valid_i | input | 1 | Eviction request valid |
| ev_ready_o | output | 1 | Request can be accepted |
| ev_src_i | input | IDX_W | Index of the evicting slice |
| ev_addr_i | input | ADDR_W | Line address of the evicted line |
| ev_dirty_i | input | 1 | Evicted line is modified |
| ev_present_i | input | NUM_SLICES | Slices already holding a copy |
| dec_valid_o | output | 1 | Decision valid |
| dec_kind_o | output | 2 | 0 transfer, 1 place, 2 drop |
| dec_dest_o | output | IDX_W | Destination slice, 0 on drop |
| dec_addr_o | output | ADDR_W | Address of the decided line |
| dec_wb_o | output | 1 | Write back to memory (drop of a dirty line) |

## Verification
A score that counts wrongly can only be seen through the outcome of a later eviction. A score that wraps instead of saturating, or a halving that arrives early or late, turns an expected placement into a drop on the first request issued after the fault. For that reason the bench drives each score to a known value and then probes it with a request. A fault in the pick or priority logic shows up on the decision of the same request, one cycle after acceptance, as a wrong kind or a wrong destination.

// File: rtl/vds_pkg.sv
package vds_pkg;

   typedef enum logic [1:0] {
      VDS_XFER  = 2'd0,
      VDS_PLACE = 2'd1,
      VDS_DROP  = 2'd2
   } vds_kind_e;

endpackage

// File: rtl/vds_sat_counter.sv
module vds_sat_counter #(
   parameter int WIDTH = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_i,
   input  logic             halve_i,
   output logic [WIDTH-1:0] count_o
);

   localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

   logic [WIDTH-1:0] count_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
      end else if (halve_i) begin
         count_q <= count_q >> 1;
      end else if (inc_i && (count_q != TOP)) begin
         count_q <= count_q + 1'b1;
      end
   end

   assign count_o = count_q;

endmodule

// File: rtl/vds_metric_bank.sv
module vds_metric_bank #(
   parameter int              NUM_SLICES = 10,
   parameter int              METRIC_W   = 6,
   parameter int              WIN_W      = 16,
   parameter logic [NUM_SLICES-1:0] FREE_MASK = '0
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic [NUM_SLICES-1:0]               fill_i,
   input  logic [WIN_W-1:0]                    window_len_i,
   output logic [NUM_SLICES-1:0][METRIC_W-1:0] metric_o,
   output logic                                decay_o
);

   logic [WIN_W-1:0] win_cnt_q;
   logic             win_on;
   logic             win_end;

   assign win_on  = (window_len_i != '0);
   assign win_end = win_on && (win_cnt_q >= (window_len_i - 1'b1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_cnt_q <= '0;
      end else if (!win_on || win_end) begin
         win_cnt_q <= '0;
      end else begin
         win_cnt_q <= win_cnt_q + 1'b1;
      end
   end

   assign decay_o = win_end;

   for (genvar g = 0; g < NUM_SLICES; g++) begin : g_slice
      if (FREE_MASK[g]) begin : g_free
         assign metric_o[g] = '0;
      end else begin : g_owned
         vds_sat_counter #(
            .WIDTH (METRIC_W)
         ) cnt_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .inc_i   (fill_i[g]),
            .halve_i (win_end),
            .count_o (metric_o[g])
         );
      end
   end

endmodule

// File: rtl/vds_copy_pick.sv
module vds_copy_pick #(
   parameter int NUM_SLICES = 10,
   parameter int IDX_W      = 4
) (
   input  logic [NUM_SLICES-1:0] present_i,
   input  logic [IDX_W-1:0]      src_i,
   output logic                  found_o,
   output logic [IDX_W-1:0]      dest_o
);

   logic [NUM_SLICES-1:0] others;

   always_comb begin
      for (int i = 0; i < NUM_SLICES; i++) begin
         others[i] = present_i[i] && (IDX_W'(i) != src_i);
      end
   end

   always_comb begin
      found_o = 1'b0;
      dest_o  = '0;
      for (int i = NUM_SLICES - 1; i >= 0; i--) begin
         if (others[i]) begin
            found_o = 1'b1;
            dest_o  = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/vds_place_pick.sv
module vds_place_pick #(
   parameter int NUM_SLICES = 10,
   parameter int METRIC_W   = 6,
   parameter int IDX_W      = 4
) (
   input  logic [NUM_SLICES-1:0][METRIC_W-1:0] metric_i,
   input  logic [IDX_W-1:0]                    src_i,
   output logic                                found_o,
   output logic [IDX_W-1:0]                    dest_o
);

   logic [METRIC_W-1:0]   src_m;
   logic [NUM_SLICES-1:0] elig;
   logic [METRIC_W-1:0]   best_m;

   always_comb begin
      src_m = '0;
      for (int i = 0; i < NUM_SLICES; i++) begin
         if (IDX_W'(i) == src_i) src_m = metric_i[i];
      end
   end

   always_comb begin
      for (int i = 0; i < NUM_SLICES; i++) begin
         elig[i] = (IDX_W'(i) != src_i) && (metric_i[i] < src_m);
      end
   end

   always_comb begin
      found_o = 1'b0;
      dest_o  = '0;
      best_m  = '0;
      for (int i = 0; i < NUM_SLICES; i++) begin
         if (elig[i] && (!found_o || (metric_i[i] < best_m))) begin
            found_o = 1'b1;
            dest_o  = IDX_W'(i);
            best_m  = metric_i[i];
         end
      end
   end

endmodule

// File: rtl/vds_victim_select.sv
module vds_victim_select #(
   parameter int NUM_SLICES = 10,
   parameter int METRIC_W   = 6,
   parameter int WIN_W      = 16,
   parameter int ADDR_W     = 32,
   parameter logic [NUM_SLICES-1:0] FREE_MASK = NUM_SLICES'(1) << (NUM_SLICES - 1),
   localparam int IDX_W     = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_SLICES-1:0] fill_i,
   input  logic [WIN_W-1:0]      window_len_i,
   input  logic                  ev_valid_i,
   output logic                  ev_ready_o,
   input  logic [IDX_W-1:0]      ev_src_i,
   input  logic [ADDR_W-1:0]     ev_addr_i,
   input  logic                  ev_dirty_i,
   input  logic [NUM_SLICES-1:0] ev_present_i,
   output logic                  dec_valid_o,
   output logic [1:0]            dec_kind_o,
   output logic [IDX_W-1:0]      dec_dest_o,
   output logic [ADDR_W-1:0]     dec_addr_o,
   output logic                  dec_wb_o
);

   import vds_pkg::*;

   if (NUM_SLICES < 2) begin : g_bad_slices
      $error("vds_victim_select: NUM_SLICES must be at least 2");
   end
   if (METRIC_W < 1) begin : g_bad_metric
      $error("vds_victim_select: METRIC_W must be at least 1");
   end
   if (WIN_W < 1) begin : g_bad_win
      $error("vds_victim_select: WIN_W must be at least 1");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("vds_victim_select: ADDR_W must be at least 1");
   end

   logic [NUM_SLICES-1:0][METRIC_W-1:0] metric_w;
   logic                                decay_w;
   logic                                copy_found;
   logic [IDX_W-1:0]                    copy_dest;
   logic                                place_found;
   logic [IDX_W-1:0]                    place_dest;
   logic                                accept;
   vds_kind_e                           kind_d;
   logic [IDX_W-1:0]                    dest_d;
   logic                                wb_d;

   logic                                ready_q;
   logic                                valid_q;
   vds_kind_e                           kind_q;
   logic [IDX_W-1:0]                    dest_q;
   logic [ADDR_W-1:0]                   addr_q;
   logic                                wb_q;

   vds_metric_bank #(
      .NUM_SLICES (NUM_SLICES),
      .METRIC_W   (METRIC_W),
      .WIN_W      (WIN_W),
      .FREE_MASK  (FREE_MASK)
   ) bank_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .fill_i       (fill_i),
      .window_len_i (window_len_i),
      .metric_o     (metric_w),
      .decay_o      (decay_w)
   );

   vds_copy_pick #(
      .NUM_SLICES (NUM_SLICES),
      .IDX_W      (IDX_W)
   ) copy_i (
      .present_i (ev_present_i),
      .src_i     (ev_src_i),
      .found_o   (copy_found),
      .dest_o    (copy_dest)
   );

   vds_place_pick #(
      .NUM_SLICES (NUM_SLICES),
      .METRIC_W   (METRIC_W),
      .IDX_W      (IDX_W)
   ) place_i (
      .metric_i (metric_w),
      .src_i    (ev_src_i),
      .found_o  (place_found),
      .dest_o   (place_dest)
   );

   assign accept = ev_valid_i && ready_q;

   always_comb begin
      if (copy_found) begin
         kind_d = VDS_XFER;
         dest_d = copy_dest;
         wb_d   = 1'b0;
      end else if (place_found) begin
         kind_d = VDS_PLACE;
         dest_d = place_dest;
         wb_d   = 1'b0;
      end else begin
         kind_d = VDS_DROP;
         dest_d = '0;
         wb_d   = ev_dirty_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready_q <= 1'b0;
         valid_q <= 1'b0;
         kind_q  <= VDS_XFER;
         dest_q  <= '0;
         addr_q  <= '0;
         wb_q    <= 1'b0;
      end else begin
         ready_q <= 1'b1;
         valid_q <= accept;
         if (accept) begin
            kind_q <= kind_d;
            dest_q <= dest_d;
            addr_q <= ev_addr_i;
            wb_q   <= wb_d;
         end
      end
   end

   assign ev_ready_o  = ready_q;
   assign dec_valid_o = valid_q;
   assign dec_kind_o  = kind_q;
   assign dec_dest_o  = dest_q;
   assign dec_addr_o  = addr_q;
   assign dec_wb_o    = wb_q;

endmodule

// File: rtl/vds_victim_select_chk.sv
module vds_victim_select_chk #(
   parameter int NUM_SLICES = 10,
   parameter int METRIC_W   = 6,
   parameter int ADDR_W     = 32,
   parameter int IDX_W      = 4
) (
   input logic                                clk,
   input logic                                rst_n,
   input logic                                ev_valid_i,
   input logic                                ev_ready_o,
   input logic [IDX_W-1:0]                    ev_src_i,
   input logic [ADDR_W-1:0]                   ev_addr_i,
   input logic [NUM_SLICES-1:0]               ev_present_i,
   input logic                                dec_valid_o,
   input logic [1:0]                          dec_kind_o,
   input logic [IDX_W-1:0]                    dec_dest_o,
   input logic [ADDR_W-1:0]                   dec_addr_o,
   input logic                                dec_wb_o,
   input logic [NUM_SLICES-1:0][METRIC_W-1:0] metric_i,
   input logic                                decay_i
);

   logic                  acc;
   logic [NUM_SLICES-1:0] src_bit;

   assign acc     = ev_valid_i && ev_ready_o;
   assign src_bit = NUM_SLICES'(1) << ev_src_i;

   assert_answer_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> dec_valid_o);

   assert_quiet_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !acc |=> !dec_valid_o);

   assert_addr_echo_R2: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> (dec_addr_o == $past(ev_addr_i)));

   assert_copy_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && ((ev_present_i & ~src_bit) != '0)) |=> (dec_kind_o == 2'd0));

   assert_never_self_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && (dec_kind_o != 2'd2)) |=> ((dec_kind_o == 2'd2) || (dec_dest_o != $past(ev_src_i))));

   assert_wb_only_on_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid_o && dec_wb_o) |-> (dec_kind_o == 2'd2));

   assert_legal_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid_o |-> (dec_kind_o != 2'd3));

   for (genvar g = 0; g < NUM_SLICES; g++) begin : g_metric_chk
      assert_no_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
         !decay_i |=> (metric_i[g] >= $past(metric_i[g])));

      assert_halved_R9: assert property (@(posedge clk) disable iff (!rst_n)
         decay_i |=> (metric_i[g] == ($past(metric_i[g]) >> 1)));
   end

endmodule

bind vds_victim_select vds_victim_select_chk #(
   .NUM_SLICES (NUM_SLICES),
   .METRIC_W   (METRIC_W),
   .ADDR_W     (ADDR_W),
   .IDX_W      (IDX_W)
) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .ev_valid_i   (ev_valid_i),
   .ev_ready_o   (ev_ready_o),
   .ev_src_i     (ev_src_i),
   .ev_addr_i    (ev_addr_i),
   .ev_present_i (ev_present_i),
   .dec_valid_o  (dec_valid_o),
   .dec_kind_o   (dec_kind_o),
   .dec_dest_o   (dec_dest_o),
   .dec_addr_o   (dec_addr_o),
   .dec_wb_o     (dec_wb_o),
   .metric_i     (metric_w),
   .decay_i      (decay_w)
);

// File: tb/vds_victim_select_tb_top.sv
module vds_victim_select_tb_top;

   localparam int N  = 10;
   localparam int IW = 4;
   localparam int AW = 32;
   localparam int WW = 16;

   localparam logic [1:0] K_XFER  = 2'd0;
   localparam logic [1:0] K_PLACE = 2'd1;
   localparam logic [1:0] K_DROP  = 2'd2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  fill = '0;
   logic [WW-1:0] window_len = '0;
   logic          ev_valid = 1'b0;
   logic          ev_ready;
   logic [IW-1:0] ev_src = '0;
   logic [AW-1:0] ev_addr = '0;
   logic          ev_dirty = 1'b0;
   logic [N-1:0]  ev_present = '0;
   logic          dec_valid;
   logic [1:0]    dec_kind;
   logic [IW-1:0] dec_dest;
   logic [AW-1:0] dec_addr;
   logic          dec_wb;

   int  n_run  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;

   always #2 clk = ~clk;

   vds_victim_select dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .fill_i       (fill),
      .window_len_i (window_len),
      .ev_valid_i   (ev_valid),
      .ev_ready_o   (ev_ready),
      .ev_src_i     (ev_src),
      .ev_addr_i    (ev_addr),
      .ev_dirty_i   (ev_dirty),
      .ev_present_i (ev_present),
      .dec_valid_o  (dec_valid),
      .dec_kind_o   (dec_kind),
      .dec_dest_o   (dec_dest),
      .dec_addr_o   (dec_addr),
      .dec_wb_o     (dec_wb)
   );

   typedef struct packed {
      logic [9:0] fmask;
      logic [7:0] fcnt;
      logic [3:0] src;
      logic [9:0] pres;
      logic       dirty;
      logic [1:0] kind;
      logic [3:0] dest;
      logic       wb;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      vec_t'({10'h000, 8'd0, 4'd2, 10'h000, 1'b1, K_DROP,  4'd0, 1'b1}), // R6 all scores zero
      vec_t'({10'h1FF, 8'd3, 4'd2, 10'h000, 1'b0, K_PLACE, 4'd9, 1'b0}), // R5 free slice lowest
      vec_t'({10'h000, 8'd0, 4'd2, 10'h090, 1'b0, K_XFER,  4'd4, 1'b0}), // R3 lowest holder
      vec_t'({10'h000, 8'd0, 4'd4, 10'h110, 1'b1, K_XFER,  4'd8, 1'b0}), // R4 own bit skipped
      vec_t'({10'h000, 8'd0, 4'd4, 10'h010, 1'b1, K_PLACE, 4'd9, 1'b0}), // R4 only own bit
      vec_t'({10'h000, 8'd0, 4'd3, 10'h100, 1'b0, K_XFER,  4'd8, 1'b0}), // R3 copy beats score
      vec_t'({10'h000, 8'd0, 4'd0, 10'h3FF, 1'b0, K_XFER,  4'd1, 1'b0}), // R4 all set
      vec_t'({10'h000, 8'd0, 4'd9, 10'h000, 1'b1, K_DROP,  4'd0, 1'b1}), // R6 dirty drop
      vec_t'({10'h200, 8'd5, 4'd9, 10'h000, 1'b0, K_DROP,  4'd0, 1'b0}), // R8 fills ignored
      vec_t'({10'h000, 8'd0, 4'd7, 10'h000, 1'b0, K_PLACE, 4'd9, 1'b0})  // R8 still zero
   };

   localparam string TAGS [NV] = '{"R6", "R5", "R3", "R4", "R4", "R3", "R4", "R6", "R8", "R8"};

   task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 ready low in reset", 64'(ev_ready), 64'd0);
      check("R1 valid low in reset", 64'(dec_valid), 64'd0);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      check("R2 ready after reset", 64'(ev_ready), 64'd1);
   endtask

   task automatic do_fills(input logic [N-1:0] mask, input int count);
      for (int k = 0; k < count; k++) begin
         @(negedge clk);
         fill = mask;
      end
      @(negedge clk);
      fill = '0;
   endtask

   task automatic do_req(input string tag, input logic [IW-1:0] src, input logic [N-1:0] pres,
                         input logic dirty, input logic [AW-1:0] addr,
                         input logic [1:0] ekind, input logic [IW-1:0] edest, input logic ewb);
      @(negedge clk);
      ev_valid   = 1'b1;
      ev_src     = src;
      ev_present = pres;
      ev_dirty   = dirty;
      ev_addr    = addr;
      @(posedge clk);
      #1;
      check(tag, {23'd0, dec_valid, dec_kind, dec_dest, dec_addr, dec_wb},
                 {23'd0, 1'b1, ekind, edest, addr, ewb});
      @(negedge clk);
      ev_valid = 1'b0;
      @(posedge clk);
      #1;
      check("R2 single-cycle answer", 64'(dec_valid), 64'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_run++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      do_reset();

      for (int v = 0; v < NV; v++) begin
         if (VECS[v].fcnt != 0) do_fills(VECS[v].fmask, int'(VECS[v].fcnt));
         do_req(TAGS[v], VECS[v].src, VECS[v].pres, VECS[v].dirty,
                32'h1000_0000 + 32'(v * 64), VECS[v].kind, VECS[v].dest, VECS[v].wb);
      end

      // R2 back-to-back requests
      @(negedge clk);
      ev_valid = 1'b1; ev_src = 4'd2; ev_present = 10'h008; ev_dirty = 1'b0; ev_addr = 32'hA000_0040;
      @(posedge clk);
      #1;
      check("R2 first of pair", {dec_valid, dec_kind, dec_dest, dec_addr}, {1'b1, K_XFER, 4'd3, 32'hA000_0040});
      @(negedge clk);
      ev_src = 4'd1; ev_present = 10'h020; ev_addr = 32'hA000_0080;
      @(posedge clk);
      #1;
      check("R2 second of pair", {dec_valid, dec_kind, dec_dest, dec_addr}, {1'b1, K_XFER, 4'd5, 32'hA000_0080});
      @(negedge clk);
      ev_valid = 1'b0;
      @(posedge clk);
      #1;
      check("R2 idle after pair", 64'(dec_valid), 64'd0);

      // R5 tie: slice 5 and free slice 9 both score zero, lower index wins
      do_reset();
      do_fills(10'h1DF, 2);
      do_req("R5 tie to lower index", 4'd2, 10'h000, 1'b0, 32'hB000_0000, K_PLACE, 4'd5, 1'b0);

      // R7 saturation: 64 fills must not wrap to zero
      do_reset();
      do_fills(10'h040, 64);
      do_req("R7 saturates", 4'd6, 10'h000, 1'b1, 32'hC000_0000, K_PLACE, 4'd0, 1'b0);

      // R9 decay by halving
      do_fills(10'h010, 1);
      do_fills(10'h020, 2);
      do_req("R9 before window", 4'd4, 10'h000, 1'b1, 32'hD000_0000, K_PLACE, 4'd0, 1'b0);
      @(negedge clk);
      window_len = 16'd4;
      repeat (4) @(posedge clk);
      @(negedge clk);
      window_len = 16'd0;
      do_req("R9 halved to zero", 4'd4, 10'h000, 1'b1, 32'hD000_0040, K_DROP, 4'd0, 1'b1);
      do_req("R9 halved to one", 4'd5, 10'h000, 1'b0, 32'hD000_0080, K_PLACE, 4'd0, 1'b0);
      repeat (20) @(negedge clk);
      do_req("R9 zero window holds", 4'd5, 10'h000, 1'b0, 32'hD000_00C0, K_PLACE, 4'd0, 1'b0);
      do_req("R10 drop code", 4'd4, 10'h000, 1'b0, 32'hD000_0100, K_DROP, 4'd0, 1'b0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule